// File: doc/BRIEF.md
# Interrupt Status Aggregator with Output Control

This block collects four event sources from a clock synchronizer into sticky status bits. Each source has its own enable bit. The enabled pending bits are ORed onto one interrupt request pin. The request pin's active level is programmable. So is its idle drive: it can be driven all the time, or left floating while inactive, with the floating state shown as a low output enable. A separate configuration bit can steer the selected-clock-fail flag onto a test data pin.

The event sources lie outside this block. Each event arrives as a one-cycle pulse. Software reaches the status, enable and configuration bits through a flat register port. Writes are synchronous. Reads are combinational and have no side effects. Register offsets are status 0x0, enable 0x1, monitor configuration 0xB and interrupt output configuration 0xC.

Top module: `irq_agg_top`

## Requirements
- R1: There are four sources, mapped to event and status bit positions as follows: bit0 is an input-clock validity change, bit1 is a failure of the selected input clock, bit2 is an operating-mode switch and bit3 is an external sync alarm. The status register at address 0x0 returns them in bits [3:0], and its upper bits read 0.
- R2: An event pulse sets its status bit at the next clock edge, whatever its enable. The bit then stays set until software clears it.
- R3: Writing address 0x0 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: The request is active while any status bit is both set and enabled. It becomes inactive only once every enabled pending bit has been cleared.
- R5: Bit0 of address 0xC selects the polarity. When it is 1 the pin is high while the request is active; when it is 0 the pin is low while active and high while inactive.
- R6: Bit1 of address 0xC selects the drive mode. When it is 1 the output enable is 1 only while the request is active; when it is 0 the output enable is always 1.
- R7: Bit0 of address 0xB routes the flag. When it is 1, the test flag equals status bit1 whatever the enables; when it is 0, the test flag is 0.
- R8: If an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R9: The enable register sits at address 0x1, bits [3:0]. A change of enable reaches the request in the cycle after the write, with no new event needed.
- R10: After reset every status, enable and configuration bit is 0, so the pin is high and the output enable is 1. Reading has no effect on any state. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | NUM_SRC | One-cycle event pulses, one per source |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address, shared by read and write |
| wrData | input | DATA_W | Register write data |
| rdData | output | DATA_W | Combinational read data for addr |
| irqPin | output | 1 | Interrupt request pin level |
| irqOe | output | 1 | Output enable of the request pin |
| testFlag | output | 1 | Selected-clock-fail flag steered to the test pin |

## Verification
A wrong status bit shows in two places in the same cycle after the edge that produced it. It appears on the status read-back, and it also appears on the request pin whenever that bit is enabled. A lost event or a missed clear therefore appears one clock after the pulse or write. An enable or configuration register holding the wrong value changes the pin level or the output enable in the cycle after the write. The sweep covers every enable mask against every event mask, and every polarity and drive-mode pair, so it reaches each of these states.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrIrqCfg;
    logic wrMonCfg;
  } regStrobes_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_ENABLE,
    RD_IRQCFG,
    RD_MONCFG
  } rdSel_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] ENABLE_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] MONCFG_ADDR = 'hB,
  parameter logic [ADDR_W-1:0] IRQCFG_ADDR = 'hC
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobes_t       strobes,
  output rdSel_t            rdSel
);
  always_comb begin
    rdSel = RD_NONE;
    unique case (addr)
      STATUS_ADDR: rdSel = RD_STATUS;
      ENABLE_ADDR: rdSel = RD_ENABLE;
      MONCFG_ADDR: rdSel = RD_MONCFG;
      IRQCFG_ADDR: rdSel = RD_IRQCFG;
      default:     rdSel = RD_NONE;
    endcase
  end

  always_comb begin
    strobes          = '0;
    strobes.wrStatus = wrEn && (rdSel == RD_STATUS);
    strobes.wrEnable = wrEn && (rdSel == RD_ENABLE);
    strobes.wrMonCfg = wrEn && (rdSel == RD_MONCFG);
    strobes.wrIrqCfg = wrEn && (rdSel == RD_IRQCFG);
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [DATA_W-1:0]  wrData,
  input  regStrobes_t        strobes,
  input  rdSel_t             rdSel,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic               irqActive,
  output logic               cfgPol,
  output logic               cfgHz,
  output logic               cfgRoute
);
  localparam int POL_BIT   = 0;
  localparam int HZ_BIT    = 1;
  localparam int ROUTE_BIT = 0;

  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_status
    logic clrHit;
    assign clrHit = strobes.wrStatus && wrData[i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            statusQ[i] <= 1'b0;
      else if (evtPulse[i]) statusQ[i] <= 1'b1;
      else if (clrHit)      statusQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= '0;
      cfgPol   <= 1'b0;
      cfgHz    <= 1'b0;
      cfgRoute <= 1'b0;
    end else begin
      if (strobes.wrEnable) enableQ <= wrData[NUM_SRC-1:0];
      if (strobes.wrIrqCfg) begin
        cfgPol <= wrData[POL_BIT];
        cfgHz  <= wrData[HZ_BIT];
      end
      if (strobes.wrMonCfg) cfgRoute <= wrData[ROUTE_BIT];
    end
  end

  assign irqActive = |(statusQ & enableQ);

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_STATUS: rdData = DATA_W'(statusQ);
      RD_ENABLE: rdData = DATA_W'(enableQ);
      RD_IRQCFG: begin
        rdData[POL_BIT] = cfgPol;
        rdData[HZ_BIT]  = cfgHz;
      end
      RD_MONCFG: rdData[ROUTE_BIT] = cfgRoute;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int LOSS_SRC    = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqPin,
  output logic               irqOe,
  output logic               testFlag
);
  regStrobes_t        strobes;
  rdSel_t             rdSel;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic               irqActive;
  logic               cfgPol;
  logic               cfgHz;
  logic               cfgRoute;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .strobes(strobes), .rdSel(rdSel)
  );

  irq_agg_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrData(wrData),
    .strobes(strobes), .rdSel(rdSel), .rdData(rdData),
    .statusQ(statusQ), .enableQ(enableQ), .irqActive(irqActive),
    .cfgPol(cfgPol), .cfgHz(cfgHz), .cfgRoute(cfgRoute)
  );

  assign irqPin   = cfgPol ? irqActive : ~irqActive;
  assign irqOe    = cfgHz ? irqActive : 1'b1;
  assign testFlag = cfgRoute & statusQ[LOSS_SRC];
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int DATA_W   = 8,
  parameter int LOSS_SRC = 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic [DATA_W-1:0]  wrData,
  input regStrobes_t        strobes,
  input logic [NUM_SRC-1:0] statusQ,
  input logic               irqActive,
  input logic               irqOe,
  input logic               cfgHz,
  input logic               testFlag,
  input logic               cfgRoute
);
  // R2, R8: every pulsed source is set one cycle later
  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((statusQ & $past(evtPulse)) == $past(evtPulse)));

  // R2: without a clear write, no status bit falls
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R3: a clear write with no events removes exactly the ones written
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrStatus && evtPulse == '0) |=>
      (statusQ == ($past(statusQ) & ~$past(wrData[NUM_SRC-1:0]))));

  // R4, R9: the request only falls after a status or enable write
  p_deassert_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqActive) |-> $past(strobes.wrStatus || strobes.wrEnable));

  // R6: a released pin implies the floating drive mode
  p_float_r6: assert property (@(posedge clk) disable iff (!rstN)
    !irqOe |-> cfgHz);

  // R7: the test flag needs routing and a pending loss bit
  p_route_r7: assert property (@(posedge clk) disable iff (!rstN)
    testFlag |-> (cfgRoute && statusQ[LOSS_SRC]));
endmodule

bind irq_agg_top irq_agg_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .LOSS_SRC(LOSS_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrData(wrData),
  .strobes(strobes), .statusQ(statusQ), .irqActive(irqActive),
  .irqOe(irqOe), .cfgHz(cfgHz), .testFlag(testFlag), .cfgRoute(cfgRoute)
);

// File: tb/sim_irq_agg_top.sv
`timescale 1ns/1ps
module sim_irq_agg_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] evtPulse = '0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irqPin, irqOe, testFlag;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_agg_top u0 (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqPin(irqPin), .irqOe(irqOe),
    .testFlag(testFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk); evtPulse = m;
    @(negedge clk); evtPulse = '0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdData;
  endtask

  task automatic checkPins(input string req, input bit act, input bit pol, input bit hz);
    check({req, " pin"}, int'(irqPin), int'(pol ? act : !act));
    check({req, " oe"}, int'(irqOe), int'(hz ? act : 1'b1));
  endtask

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    // R10 reset state
    readReg(4'h0, d); check("R10 status reset", d, 0);
    readReg(4'h1, d); check("R10 enable reset", d, 0);
    readReg(4'hC, d); check("R10 irqcfg reset", d, 0);
    readReg(4'hB, d); check("R10 moncfg reset", d, 0);
    check("R10 pin reset", irqPin, 1);
    check("R10 oe reset", irqOe, 1);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R9: exhaustive enable x event sweep
    for (int en = 0; en < 16; en++) begin
      writeReg(4'h1, 8'(en));
      for (int ev = 0; ev < 16; ev++) begin
        writeReg(4'h0, 8'hFF);
        readReg(4'h0, d); check("R3 clear all", d, 0);
        pulse(4'(ev));
        readReg(4'h0, d); check("R1 R2 status capture", d, ev);
        checkPins("R4 request", (en & ev) != 0, 1'b0, 1'b0);
      end
    end

    // R5 R6: every polarity/drive pair, active and inactive
    for (int c = 0; c < 4; c++) begin
      writeReg(4'hC, 8'(c));
      readReg(4'hC, d); check("R5 R6 cfg readback", d, c);
      writeReg(4'h1, 8'h0);
      writeReg(4'h0, 8'hFF);
      pulse(4'h4);
      checkPins("R5 R6 inactive", 1'b0, c[0], c[1]);
      writeReg(4'h1, 8'h4);
      checkPins("R5 R6 active", 1'b1, c[0], c[1]);
    end
    writeReg(4'hC, 8'h0);

    // R3 partial clears, zero writes keep bits
    writeReg(4'h0, 8'hFF); pulse(4'hF);
    writeReg(4'h0, 8'h05);
    readReg(4'h0, d); check("R3 partial clear", d, 8'h0A);
    writeReg(4'h0, 8'h00);
    readReg(4'h0, d); check("R3 zero write", d, 8'h0A);

    // R4 deassert only after every enabled pending bit cleared
    writeReg(4'h0, 8'hFF); writeReg(4'h1, 8'h03); pulse(4'h3);
    writeReg(4'h0, 8'h01);
    checkPins("R4 one left", 1'b1, 1'b0, 1'b0);
    writeReg(4'h0, 8'h02);
    checkPins("R4 all cleared", 1'b0, 1'b0, 1'b0);

    // R8 collision of event and clear on same bit
    writeReg(4'h0, 8'hFF); pulse(4'h2);
    @(negedge clk); wrEn = 1'b1; addr = 4'h0; wrData = 8'h02; evtPulse = 4'h2;
    @(negedge clk); wrEn = 1'b0; wrData = '0; evtPulse = '0;
    readReg(4'h0, d); check("R8 collision keeps bit", d, 8'h02);

    // R9 enable change alone drives request next cycle
    writeReg(4'h1, 8'h00);
    checkPins("R9 disabled", 1'b0, 1'b0, 1'b0);
    @(negedge clk); wrEn = 1'b1; addr = 4'h1; wrData = 8'h02;
    #0.5 check("R9 before edge", irqPin, 1);
    @(negedge clk); wrEn = 1'b0;
    check("R9 after edge", irqPin, 0);

    // R7 test flag routing, independent of enable
    writeReg(4'h1, 8'h00);
    check("R7 unrouted", testFlag, 0);
    writeReg(4'hB, 8'h01);
    readReg(4'hB, d); check("R7 moncfg readback", d, 1);
    check("R7 routed", testFlag, 1);
    writeReg(4'h0, 8'h02);
    check("R7 routed cleared", testFlag, 0);
    pulse(4'hD);
    check("R7 other sources", testFlag, 0);
    writeReg(4'hB, 8'h00);

    // R10 reads have no side effect; unmapped reads 0
    writeReg(4'h0, 8'hFF); pulse(4'h9);
    readReg(4'h0, d); @(negedge clk); readReg(4'h0, d2);
    check("R10 reread", d2, d);
    check("R10 reread value", d2, 8'h09);
    readReg(4'h7, d); check("R10 unmapped", d, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule